// File: doc/BRIEF.md
# ADC Channel Sequencer with Result Ring

This block runs the conversions of an eight-input successive-approximation converter in a set order. A start command loads four settings: the first input to convert, how many conversions make up the sequence, whether the input number steps after each conversion, and whether results pile up in a running ring. The block then asks the external converter for one conversion at a time. It waits for each returned 16-bit sample before it asks for the next one.

Every accepted sample goes into one of eight result registers. A 3-bit store pointer picks the register and wraps around after register 7. In ring (FIFO) mode the pointer keeps its value from one sequence to the next, so a new sequence can begin storing anywhere in the ring. Otherwise each start sends the pointer back to register 0.

The pointer value and a sequence-complete flag are always visible on status pins. Any register can be read through a plain combinational read port.

The request and the sample each pass through a valid/ready handshake:
- A request stays valid, with a stable channel number, until the converter raises ready.
- The sequencer raises sample-ready only while it waits for the result of the one request it has issued.
- A sample is taken in the cycle where valid and ready are both high. The converter must hold a sample until it is taken.

Top module: `adc_seq_ring`

## Requirements
- R1: After reset the store pointer is 0, the complete flag is low, no request or sample-ready is raised, and all eight result registers read 0.
- R2: The 4-bit length code gives that many conversions for codes 1 to 8. Codes 0 and 9 to 15 give eight conversions. After exactly that many samples no further request is issued.
- R3: The first request of a sequence carries the 3-bit start channel. With stepping enabled, each later request carries the previous channel plus one, wrapping from 7 to 0 (start 6, length 5 gives 6, 7, 0, 1, 2).
- R4: With stepping disabled, every request of the sequence carries the start channel.
- R5: Each accepted sample is written into the register indexed by the store pointer. The pointer then advances by one modulo 8, and its value is shown on the status output at all times.
- R6: In ring mode a start leaves the store pointer unchanged (pointer 5 with five conversions fills registers 5, 6, 7, 0, 1).
- R7: Outside ring mode a start clears the store pointer to 0, so the first result lands in register 0.
- R8: The complete flag rises in the cycle after the last sample of a sequence is stored. It stays high until a start, which clears it.
- R9: A request stays raised with a stable channel until accepted. At most one conversion is outstanding, and sample-ready is high only between request acceptance and sample acceptance.
- R10: A start that arrives in the same cycle as a sample handshake aborts the sequence. That sample is not stored, the pointer does not advance, and the new sequence's first request follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle start command; loads settings and aborts any running sequence |
| start_chan | input | 3 | First input channel of the sequence |
| seq_len | input | 4 | Conversion count code (0 and values above 8 mean eight) |
| multi_en | input | 1 | Step channel after each conversion |
| fifo_en | input | 1 | Keep store pointer across starts |
| req_valid | output | 1 | Conversion request valid |
| req_ready | input | 1 | Converter accepts request |
| req_chan | output | 3 | Channel for the requested conversion |
| smp_valid | input | 1 | Converter sample valid |
| smp_ready | output | 1 | Sequencer can take a sample |
| smp_data | input | 16 | Converted sample |
| rd_idx | input | 3 | Result register index to read |
| rd_data | output | 16 | Content of the selected result register |
| cnt | output | 3 | Store pointer (next register to be written) |
| seq_done | output | 1 | Sequence complete flag |

## Verification
Two events can land on the same clock edge: a new start command and the handshake that stores a sample. Start is given priority, and the abort test is built to hit that edge. In ring mode, one sample is first stored normally. On the very next sample handshake the test drives start with a different start channel in the same cycle.

The collision is judged at the ports in three ways:
- The pointer must hold its value and the complete flag must stay low.
- The register the pointer names must still hold its previous content.
- The next request must carry the new start channel. The new sequence must then fill the ring from the unchanged pointer.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } seq_st_t;
endpackage

// File: rtl/seq_ctrl.sv
module seq_ctrl import adc_seq_pkg::*; #(
  parameter int NCH    = 8,
  parameter int LENW   = 4,
  parameter int MAXLEN = 8,
  localparam int CHW   = $clog2(NCH),
  localparam int CW    = $clog2(MAXLEN + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [CHW-1:0] start_chan,
  input  logic [LENW-1:0] seq_len,
  input  logic           multi_en,
  input  logic           req_ready,
  input  logic           smp_valid,
  output logic           req_valid,
  output logic [CHW-1:0] req_chan,
  output logic           smp_ready,
  output logic           store,
  output logic           seq_done
);
  seq_st_t        st_q;
  logic [CHW-1:0] chan_q;
  logic [CW-1:0]  left_q;
  logic [CW-1:0]  len_eff;
  logic           multi_q;
  logic           done_q;

  // zero and oversize codes mean a full ring of conversions
  always_comb begin
    if (seq_len == '0 || int'(seq_len) > MAXLEN) len_eff = CW'(MAXLEN);
    else                                          len_eff = CW'(seq_len);
  end

  function automatic logic [CHW-1:0] next_chan(input logic [CHW-1:0] c);
    return (int'(c) == NCH - 1) ? '0 : c + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      chan_q  <= '0;
      left_q  <= '0;
      multi_q <= 1'b0;
      done_q  <= 1'b0;
    end else if (start) begin
      st_q    <= ST_REQ;
      chan_q  <= start_chan;
      left_q  <= len_eff;
      multi_q <= multi_en;
      done_q  <= 1'b0;
    end else begin
      case (st_q)
        ST_REQ: if (req_ready) st_q <= ST_WAIT;
        ST_WAIT: if (smp_valid) begin
          if (left_q == CW'(1)) begin
            st_q   <= ST_IDLE;
            done_q <= 1'b1;
          end else begin
            st_q   <= ST_REQ;
            left_q <= left_q - 1'b1;
            if (multi_q) chan_q <= next_chan(chan_q);
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_valid = (st_q == ST_REQ);
  assign req_chan  = chan_q;
  assign smp_ready = (st_q == ST_WAIT);
  assign store     = smp_ready && smp_valid && !start;
  assign seq_done  = done_q;
endmodule

// File: rtl/ring_cnt.sv
module ring_cnt #(
  parameter int NREG = 8,
  localparam int RW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          fifo_en,
  input  logic          step,
  output logic [RW-1:0] cnt
);
  logic [RW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (start && !fifo_en) cnt_q <= '0;
    else if (step)              cnt_q <= (int'(cnt_q) == NREG - 1) ? '0 : cnt_q + 1'b1;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/result_ring.sv
module result_ring #(
  parameter int NREG = 8,
  parameter int DW   = 16,
  localparam int RW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [RW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [RW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] regs [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)                             regs[i] <= '0;
      else if (we && waddr == RW'(i))         regs[i] <= wdata;
    end
  end

  assign rdata = regs[raddr];
endmodule

// File: rtl/adc_seq_ring.sv
module adc_seq_ring #(
  parameter int NCH   = 8,
  parameter int NREG  = 8,
  parameter int DW    = 16,
  parameter int LENW  = 4,
  localparam int CHW  = $clog2(NCH),
  localparam int RW   = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [CHW-1:0]  start_chan,
  input  logic [LENW-1:0] seq_len,
  input  logic            multi_en,
  input  logic            fifo_en,
  output logic            req_valid,
  input  logic            req_ready,
  output logic [CHW-1:0]  req_chan,
  input  logic            smp_valid,
  output logic            smp_ready,
  input  logic [DW-1:0]   smp_data,
  input  logic [RW-1:0]   rd_idx,
  output logic [DW-1:0]   rd_data,
  output logic [RW-1:0]   cnt,
  output logic            seq_done
);
  logic store;

  seq_ctrl #(.NCH(NCH), .LENW(LENW), .MAXLEN(NREG)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .start_chan(start_chan),
    .seq_len(seq_len), .multi_en(multi_en), .req_ready(req_ready),
    .smp_valid(smp_valid), .req_valid(req_valid), .req_chan(req_chan),
    .smp_ready(smp_ready), .store(store), .seq_done(seq_done)
  );

  ring_cnt #(.NREG(NREG)) u_cnt (
    .clk(clk), .rst_n(rst_n), .start(start), .fifo_en(fifo_en),
    .step(store), .cnt(cnt)
  );

  result_ring #(.NREG(NREG), .DW(DW)) u_ring (
    .clk(clk), .rst_n(rst_n), .we(store), .waddr(cnt), .wdata(smp_data),
    .raddr(rd_idx), .rdata(rd_data)
  );
endmodule

// File: rtl/adc_seq_ring_chk.sv
module adc_seq_ring_chk #(
  parameter int NCH  = 8,
  parameter int NREG = 8,
  localparam int CHW = $clog2(NCH),
  localparam int RW  = $clog2(NREG)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic           fifo_en,
  input logic           req_valid,
  input logic           req_ready,
  input logic [CHW-1:0] req_chan,
  input logic           smp_valid,
  input logic           smp_ready,
  input logic [RW-1:0]  cnt,
  input logic           seq_done
);
  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready && !start |=> req_valid && $stable(req_chan));

  p_one_out_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && smp_ready));

  p_cnt_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid && smp_ready && !start |=> cnt == RW'($past(cnt) + 1'b1));

  p_fifo_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start && fifo_en |=> cnt == $past(cnt));

  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start && !fifo_en |=> cnt == '0);

  p_done_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !seq_done);

  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |-> !req_valid && !smp_ready);

  p_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start && smp_valid && smp_ready |=> req_valid && !smp_ready);
endmodule

bind adc_seq_ring adc_seq_ring_chk #(.NCH(NCH), .NREG(NREG)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .fifo_en(fifo_en),
  .req_valid(req_valid), .req_ready(req_ready), .req_chan(req_chan),
  .smp_valid(smp_valid), .smp_ready(smp_ready), .cnt(cnt), .seq_done(seq_done)
);

// File: tb/sim_adc_seq_ring.sv
`timescale 1ns/1ps
module sim_adc_seq_ring;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  start_chan = '0;
  logic [3:0]  seq_len = '0;
  logic        multi_en = 1'b0;
  logic        fifo_en = 1'b0;
  logic        req_valid;
  logic        req_ready = 1'b1;
  logic [2:0]  req_chan;
  logic        smp_valid = 1'b0;
  logic        smp_ready;
  logic [15:0] smp_data = '0;
  logic [2:0]  rd_idx = '0;
  logic [15:0] rd_data;
  logic [2:0]  cnt;
  logic        seq_done;

  int checks = 0;
  int errors = 0;
  int mcnt = 0;
  int tagc = 0;
  bit ended = 1'b0;
  logic [15:0] exp_reg [8];

  always #2.5 clk = ~clk;

  adc_seq_ring u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .start_chan(start_chan),
    .seq_len(seq_len), .multi_en(multi_en), .fifo_en(fifo_en),
    .req_valid(req_valid), .req_ready(req_ready), .req_chan(req_chan),
    .smp_valid(smp_valid), .smp_ready(smp_ready), .smp_data(smp_data),
    .rd_idx(rd_idx), .rd_data(rd_data), .cnt(cnt), .seq_done(seq_done)
  );

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic issue_start(input int sc, input int ln, input bit mu, input bit fi);
    @(negedge clk);
    start_chan = 3'(sc); seq_len = 4'(ln); multi_en = mu; fifo_en = fi; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (!fi) mcnt = 0;
    chk(seq_done == 1'b0, "R8 flag cleared by start", int'(seq_done), 0);
  endtask

  task automatic wait_req();
    int t = 0;
    while (!req_valid && t < 50) begin
      @(negedge clk);
      t++;
    end
    chk(req_valid == 1'b1, "R9 request raised", int'(req_valid), 1);
  endtask

  // one conversion: request check, handshake, sample delivery
  task automatic one_conv(input int ech, input string rtag);
    logic [15:0] d;
    wait_req();
    chk(int'(req_chan) == ech, rtag, int'(req_chan), ech);
    @(negedge clk);
    chk(smp_ready == 1'b1 && req_valid == 1'b0, "R9 single outstanding",
        int'({req_valid, smp_ready}), 1);
    tagc++;
    d = 16'((tagc * 131 + ech * 4099 + 7) & 16'hFFFF);
    smp_valid = 1'b1; smp_data = d;
    @(negedge clk);
    smp_valid = 1'b0;
    exp_reg[mcnt] = d;
    mcnt = (mcnt + 1) % 8;
    chk(int'(cnt) == mcnt, "R5 pointer advance", int'(cnt), mcnt);
  endtask

  task automatic read_all(input string rtag);
    for (int i = 0; i < 8; i++) begin
      rd_idx = 3'(i);
      #0.5;
      chk(rd_data == exp_reg[i], rtag, int'(rd_data), int'(exp_reg[i]));
    end
  endtask

  task automatic run_seq(input int sc, input int ln, input bit mu, input bit fi);
    int n;
    n = (ln == 0 || ln > 8) ? 8 : ln;
    issue_start(sc, ln, mu, fi);
    for (int k = 0; k < n; k++) begin
      one_conv(mu ? (sc + k) % 8 : sc, mu ? "R3 stepped channel" : "R4 fixed channel");
      if (k < n - 1) chk(seq_done == 1'b0, "R2 not done early", int'(seq_done), 0);
    end
    chk(seq_done == 1'b1, "R8 flag after last store", int'(seq_done), 1);
    repeat (3) @(negedge clk);
    chk(req_valid == 1'b0, "R2 no extra request", int'(req_valid), 0);
    chk(seq_done == 1'b1, "R8 flag held", int'(seq_done), 1);
    read_all(fi ? "R6 ring placement" : "R7 placement from zero");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      ended = 1'b1;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) exp_reg[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(cnt == 3'd0, "R1 pointer reset", int'(cnt), 0);
    chk(seq_done == 1'b0, "R1 flag reset", int'(seq_done), 0);
    chk(req_valid == 1'b0 && smp_ready == 1'b0, "R1 handshakes idle",
        int'({req_valid, smp_ready}), 0);
    read_all("R1 registers cleared");

    // worked case: pointer 5, start 6, five conversions, stepping, ring mode
    run_seq(0, 5, 1'b1, 1'b1);
    chk(mcnt == 5, "R6 setup pointer", mcnt, 5);
    run_seq(6, 5, 1'b1, 1'b1);
    chk(int'(cnt) == 2, "R6 pointer after wrap", int'(cnt), 2);
    run_seq(6, 5, 1'b1, 1'b0);

    // sweep over all settings
    for (int fi = 0; fi < 2; fi++)
      for (int mu = 0; mu < 2; mu++)
        for (int ln = 0; ln < 16; ln++)
          for (int sc = 0; sc < 8; sc += 3)
            run_seq(sc, ln, 1'(mu), 1'(fi));

    // back-pressure on the request (R9)
    issue_start(4, 2, 1'b1, 1'b1);
    req_ready = 1'b0;
    for (int w = 0; w < 5; w++) begin
      @(negedge clk);
      chk(req_valid == 1'b1 && req_chan == 3'd4 && smp_ready == 1'b0,
          "R9 request held", int'(req_chan), 4);
    end
    req_ready = 1'b1;
    one_conv(4, "R3 first after stall");
    one_conv(5, "R3 second after stall");

    // abort collision (R10): start in same cycle as sample handshake
    issue_start(3, 4, 1'b1, 1'b1);
    one_conv(3, "R3 before abort");
    wait_req();
    @(negedge clk);
    chk(smp_ready == 1'b1, "R10 waiting for sample", int'(smp_ready), 1);
    smp_valid = 1'b1; smp_data = 16'hDEAD;
    start = 1'b1; start_chan = 3'd5; seq_len = 4'd2; multi_en = 1'b1; fifo_en = 1'b1;
    @(negedge clk);
    start = 1'b0; smp_valid = 1'b0;
    chk(int'(cnt) == mcnt, "R10 pointer not advanced", int'(cnt), mcnt);
    chk(seq_done == 1'b0, "R10 flag low", int'(seq_done), 0);
    chk(req_valid == 1'b1 && req_chan == 3'd5, "R10 new first request",
        int'(req_chan), 5);
    rd_idx = 3'(mcnt);
    #0.5;
    chk(rd_data == exp_reg[mcnt], "R10 sample dropped", int'(rd_data), int'(exp_reg[mcnt]));
    one_conv(5, "R10 new sequence ch");
    one_conv(6, "R10 new sequence ch");
    @(negedge clk);
    chk(seq_done == 1'b1, "R10 new sequence completes", int'(seq_done), 1);
    read_all("R10 ring after abort");

    ended = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule